// File: doc/BRIEF.md
# Serial DAC Write Frame Engine

This block turns one host request into one 16-bit command word and shifts that word out to a serial-input precision DAC. There are three kinds of request. A data write carries a 12-bit sample, or a 10-bit sample that the block left-justifies. A reference write carries a 2-bit reference-selection code. A power-down write carries no payload. A speed-mode bit is set in every word the block builds.

The block drives the frame in a fixed order. Chip select goes low first, then frame sync. The word then goes out MSB first on a generated serial clock that idles high. Each bit changes on the falling edge and is captured by the DAC on the following rising edge. Frame sync rises first and chip select rises last. Guard intervals of at least one serial clock period surround the clocked part of the frame.

Requests enter through a valid/ready pair. Ready is low for the whole frame. A valid that is seen while ready is low is not captured and is not queued, so a requester that needs the write must hold valid until ready returns. Busy and a one-cycle done pulse are plain status pins.

Top module: `dac_frame_tx`

## Requirements
- R1: Each frame clocks exactly 16 bits, MSB first. A bit is placed on the serial data pin at a falling serial clock edge and does not change while the clock is high.
- R2: A data write (kind 2'b00) with the resolution flag low sends 0x4000 | data[11:0].
- R3: A data write with the resolution flag high sends 0x4000 | (data[9:0] << 2), so the two LSBs are zero and data bits 11:10 are dropped.
- R4: A reference write (kind 2'b01) sends 0xC000 | ref[1:0]. Bit 15 is the register-select pattern and the data input has no effect.
- R5: A power-down write (kind[1] = 1) sends 0x6000 whatever kind[0], data and ref hold, so power-down outranks both other kinds.
- R6: Bit 14, the speed-mode bit, is set in every word of every kind.
- R7: The serial clock is high whenever the block is not busy and whenever frame sync is high.
- R8: Frame sync is low only while chip select is low. Chip select falls before frame sync falls, and frame sync rises before chip select rises.
- R9: At least one serial clock period (2*HALF_DIV clocks) separates the frame sync fall from the first serial clock edge. The same minimum separates the last serial clock edge from the frame sync rise.
- R10: A request is accepted when valid and ready are both high. Busy is high and chip select is low from the next cycle, and busy stays high until chip select is released.
- R11: A valid that arrives while busy is ignored. It starts no frame, and the frame in progress is not changed.
- R12: Done is a one-cycle pulse in the cycle in which chip select returns high.
- R13: With the default divider, a frame takes no more than 500 clocks from acceptance to done. At a 50 MHz system clock this supports an update rate of 100 kHz or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Block can accept a request (not busy) |
| cmd_kind | input | 2 | 00 data, 01 reference, 1x power-down |
| cmd_res10 | input | 1 | 1 = data is 10-bit and is left-justified |
| cmd_data | input | 12 | Sample value |
| cmd_ref | input | 2 | Reference-selection code |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame ends |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_fs_n | output | 1 | Frame sync, active low |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdo | output | 1 | Serial data to the DAC |

## Verification
The assertions assume that reset is held until the clock is running. They also assume that cmd_valid is never X after reset, because the acceptance property samples it on every edge. The bench drives every request input at the falling system clock edge, so no input changes near a sampling edge. It keeps cmd_valid at a known 0 except during deliberate one-cycle requests. One of these requests is placed inside a running frame on purpose, to exercise the ignore path without breaking these assumptions.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
  localparam int WORD_W = 16;

  localparam logic [1:0] KIND_DATA = 2'b00;
  localparam logic [1:0] KIND_REF  = 2'b01;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CS_LEAD,
    PH_FS_LEAD,
    PH_SHIFT,
    PH_FS_TRAIL,
    PH_CS_TRAIL
  } phase_t;
endpackage

// File: rtl/dac_word_build.sv
module dac_word_build
  import dac_frame_pkg::*;
#(
  parameter int PD_BIT   = 13,
  parameter int SEL_BIT  = 15,
  parameter int FAST_BIT = 14
) (
  input  logic [1:0]        kind,
  input  logic              res10,
  input  logic [11:0]       data,
  input  logic [1:0]        refsel,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    if (kind[1]) begin
      // power-down outranks every other kind
      word[PD_BIT] = 1'b1;
    end else if (kind == KIND_REF) begin
      word[SEL_BIT] = 1'b1;
      word[1:0]     = refsel;
    end else if (res10) begin
      word[11:0] = {data[9:0], 2'b00};
    end else begin
      word[11:0] = data;
    end
    word[FAST_BIT] = 1'b1;
  end
endmodule

// File: rtl/dac_sclk_gen.sv
module dac_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
  import dac_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              fs_n,
  output logic              sclk,
  output logic              sdo
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(2 * WORD_W - 1);
  localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(1);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      shreg <= '0;
      done  <= 1'b0;
      cs_n  <= 1'b1;
      fs_n  <= 1'b1;
      sclk  <= 1'b1;
      sdo   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          shreg <= word;
          cs_n  <= 1'b0;
          cnt   <= '0;
          ph    <= PH_CS_LEAD;
        end
        PH_CS_LEAD: if (tick) begin
          if (cnt == GUARD_LAST) begin
            fs_n <= 1'b0;
            cnt  <= '0;
            ph   <= PH_FS_LEAD;
          end else cnt <= cnt + 1'b1;
        end
        PH_FS_LEAD: if (tick) begin
          if (cnt == GUARD_LAST) begin
            cnt <= '0;
            ph  <= PH_SHIFT;
          end else cnt <= cnt + 1'b1;
        end
        PH_SHIFT: if (tick) begin
          cnt <= cnt + 1'b1;
          if (!cnt[0]) begin
            sclk  <= 1'b0;
            sdo   <= shreg[WORD_W-1];
            shreg <= {shreg[WORD_W-2:0], 1'b0};
          end else begin
            sclk <= 1'b1;
            if (cnt == SHIFT_LAST) begin
              cnt <= '0;
              ph  <= PH_FS_TRAIL;
            end
          end
        end
        PH_FS_TRAIL: if (tick) begin
          if (cnt == GUARD_LAST) begin
            fs_n <= 1'b1;
            cnt  <= '0;
            ph   <= PH_CS_TRAIL;
          end else cnt <= cnt + 1'b1;
        end
        PH_CS_TRAIL: if (tick) begin
          if (cnt == GUARD_LAST) begin
            cs_n <= 1'b1;
            done <= 1'b1;
            cnt  <= '0;
            ph   <= PH_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_frame_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PD_BIT   = 13,
  parameter int SEL_BIT  = 15,
  parameter int FAST_BIT = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_kind,
  input  logic        cmd_res10,
  input  logic [11:0] cmd_data,
  input  logic [1:0]  cmd_ref,
  output logic        busy,
  output logic        done,
  output logic        dac_cs_n,
  output logic        dac_fs_n,
  output logic        dac_sclk,
  output logic        dac_sdo
);
  logic [WORD_W-1:0] word;
  logic              tick;
  logic              start;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && cmd_ready;

  dac_word_build #(
    .PD_BIT(PD_BIT), .SEL_BIT(SEL_BIT), .FAST_BIT(FAST_BIT)
  ) u_build (
    .kind(cmd_kind), .res10(cmd_res10), .data(cmd_data),
    .refsel(cmd_ref), .word(word)
  );

  dac_sclk_gen #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  dac_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word), .tick(tick),
    .busy(busy), .done(done), .cs_n(dac_cs_n), .fs_n(dac_fs_n),
    .sclk(dac_sclk), .sdo(dac_sdo)
  );
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic dac_cs_n,
  input logic dac_fs_n,
  input logic dac_sclk,
  input logic dac_sdo
);
  assert_sdo_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_fs_n && dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || dac_fs_n) |-> dac_sclk);

  assert_fs_in_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_fs_n |-> !dac_cs_n);

  assert_fs_fall_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_fs_n) |-> $past(!dac_cs_n));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !dac_cs_n));

  assert_idle_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_cs_n);

  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dac_cs_n) |=> (busy || dac_cs_n));

  assert_done_at_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> done);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dac_frame_tx dac_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .dac_cs_n(dac_cs_n), .dac_fs_n(dac_fs_n),
  .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
);

// File: tb/dac_frame_tx_bench.sv
`timescale 1ns/1ps
module dac_frame_tx_bench;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic cmd_res10 = 1'b0;
  logic [11:0] cmd_data = '0;
  logic [1:0] cmd_ref = '0;
  logic cmd_ready, busy, done, dac_cs_n, dac_fs_n, dac_sclk, dac_sdo;

  always #10 clk = ~clk;

  dac_frame_tx #(.HALF_DIV(HALF_DIV)) u_dac_frame_tx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_res10(cmd_res10), .cmd_data(cmd_data),
    .cmd_ref(cmd_ref), .busy(busy), .done(done), .dac_cs_n(dac_cs_n),
    .dac_fs_n(dac_fs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // cycle count advances on the falling edge so edge stamps are unambiguous
  int cyc = 0;
  always @(negedge clk) cyc++;

  // serial monitor
  logic [15:0] cap = '0;
  int bits = 0;
  int frames = 0;
  logic [15:0] last_word = '0;
  int last_bits = 0;
  bit in_frame = 1'b0;
  bit first_fall = 1'b0;
  int t_cs_fall = 0, t_fs_fall = 0, t_sclk_first = 0;
  int t_sclk_last = 0, t_fs_rise = 0, t_cs_rise = 0;

  always @(negedge dac_cs_n) t_cs_fall = cyc;
  always @(posedge dac_cs_n) if (rst_n) t_cs_rise = cyc;
  always @(negedge dac_fs_n) begin
    in_frame = 1'b1; bits = 0; first_fall = 1'b0; t_fs_fall = cyc;
  end
  always @(posedge dac_fs_n) if (in_frame) begin
    in_frame = 1'b0; last_word = cap; last_bits = bits; frames++;
    t_fs_rise = cyc;
  end
  always @(negedge dac_sclk) if (in_frame && !first_fall) begin
    first_fall = 1'b1; t_sclk_first = cyc;
  end
  always @(posedge dac_sclk) if (in_frame) begin
    cap = {cap[14:0], dac_sdo}; bits++; t_sclk_last = cyc;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_ge(string req, int act, int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic r10,
                      input logic [11:0] d, input logic [1:0] rf,
                      output int lat);
    int t0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_kind = k; cmd_res10 = r10; cmd_data = d; cmd_ref = rf;
    cmd_valid = 1'b1; t0 = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    lat = cyc - t0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R7 reset sclk", {31'd0, dac_sclk}, 32'd1);
    check("R10 reset cs_n", {31'd0, dac_cs_n}, 32'd1);
    check("R8 reset fs_n", {31'd0, dac_fs_n}, 32'd1);
    check("R10 reset ready", {31'd0, cmd_ready}, 32'd1);
  endtask

  task automatic t_data12();
    int lat;
    send(2'b00, 1'b0, 12'h7FC, 2'd3, lat);
    check("R2 data12 word", {16'd0, last_word}, 32'h47FC);
    check("R1 bit count", last_bits, 16);
    send(2'b00, 1'b0, 12'hA35, 2'd0, lat);
    check("R2 data12 pattern", {16'd0, last_word}, 32'h4A35);
    check("R13 frame latency", {31'd0, lat <= 500}, 32'd1);
  endtask

  task automatic t_data10();
    int lat;
    send(2'b00, 1'b1, 12'hFFF, 2'd0, lat);
    check("R3 data10 full", {16'd0, last_word}, 32'h4FFC);
    send(2'b00, 1'b1, 12'h1FF, 2'd0, lat);
    check("R3 data10 mid", {16'd0, last_word}, 32'h47FC);
  endtask

  task automatic t_control();
    int lat;
    send(2'b01, 1'b0, 12'hFFF, 2'd2, lat);
    check("R4 reference write", {16'd0, last_word}, 32'hC002);
    check("R6 fast bit ref", {31'd0, last_word[14]}, 32'd1);
  endtask

  task automatic t_powerdown();
    int lat;
    send(2'b11, 1'b1, 12'hABC, 2'd3, lat);
    check("R5 power-down priority", {16'd0, last_word}, 32'h6000);
    send(2'b10, 1'b0, 12'h000, 2'd0, lat);
    check("R5 power-down plain", {16'd0, last_word}, 32'h6000);
    check("R6 fast bit pd", {31'd0, last_word[14]}, 32'd1);
  endtask

  task automatic t_framing();
    int lat;
    send(2'b00, 1'b0, 12'h555, 2'd0, lat);
    check_ge("R8 cs before fs", t_fs_fall - t_cs_fall, 1);
    check_ge("R8 fs release before cs", t_cs_rise - t_fs_rise, 1);
    check_ge("R9 fs lead", t_sclk_first - t_fs_fall, 2 * HALF_DIV);
    check_ge("R9 fs trail", t_fs_rise - t_sclk_last, 2 * HALF_DIV);
    check("R7 sclk idle after frame", {31'd0, dac_sclk}, 32'd1);
    check("R12 done cleared", {31'd0, done}, 32'd0);
  endtask

  task automatic t_ignore_busy();
    int f0;
    f0 = frames;
    @(negedge clk);
    cmd_kind = 2'b00; cmd_res10 = 1'b0; cmd_data = 12'h123; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 busy during frame", {31'd0, busy}, 32'd1);
    cmd_kind = 2'b10; cmd_data = 12'hFFF; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (100) @(negedge clk);
    check("R11 only one frame", frames - f0, 1);
    check("R11 frame unchanged", {16'd0, last_word}, 32'h4123);
    check("R11 idle after", {31'd0, dac_cs_n}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_data12();
    t_data10();
    t_control();
    t_powerdown();
    t_framing();
    t_ignore_busy();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule